// File: doc/BRIEF.md
# Supply Voltage Supervisor Controller

This block is the digital half of a supply supervisor. Five comparator outputs come in as asynchronous levels: supply below the power-on re-arm point, below the high and the low detect thresholds, and below the high and the low warning thresholds. Each level passes through a two-flop synchronizer. The detect and warning levels must also persist for a programmable number of clocks before they count.

From these levels the block drives a system reset, a detect interrupt and a warning interrupt. It keeps a detect flag, a warning flag and two reset-source bits, and it tells the power manager whether a stop request should enter the low-power mode that keeps detection running. A low-voltage event either resets the chip or raises a flag and an interrupt, as software selects. Reset is held until the supply has recovered. The flags are cleared by writing one to acknowledge bits.

Software reaches the block through a four-word register file. Writes take effect on a clock edge. Reads are combinational.

Top module: `svs_ctrl`

## Requirements
- R1: When the supply is below the re-arm level, the system reset output is asserted and the control and filter registers return to their defaults. The control default is 0x03 and the filter default is 4. After the supply rises above re-arm, reset stays asserted until the supply is above the low detect threshold, whatever the threshold select is.
- R2: The reset-source register at address 2 has a power-on bit (bit 0) and a low-voltage bit (bit 1). A power-on condition sets both bits. Writing 1 to a bit clears that bit. A set in the same cycle as a clear wins.
- R3: Control register at address 0: bit 0 enables detection and bit 4 selects the detect threshold (1 = high, 0 = low). While bit 0 is 0, no detect flag, no warning flag and no low-voltage reset arise.
- R4: When bit 1 of the control register is set and a qualified detection occurs, reset is asserted. Reset is released on the clock after the supply is back above the selected detect threshold. The low-voltage source bit is set at that release, not earlier.
- R5: When detection is enabled and bit 1 is clear, a qualified detection sets the detect flag (status bit 0). The detect interrupt equals the flag ANDed with control bit 2.
- R6: Status address 1: writing 1 to bit 1 clears the detect flag and writing 1 to bit 3 clears the warning flag. Both acknowledge bits always read 0. A flag whose set condition holds in the same cycle as the acknowledge stays set.
- R7: The warning flag (status bit 2) is set when detection is enabled and the supply is below the selected warning threshold but above the selected detect threshold. Control bit 5 selects the warning threshold (1 = high). The warning interrupt equals the flag ANDed with control bit 6.
- R8: A detect or warning level counts only after it has been seen on as many consecutive clocks as the filter limit at address 3. A shorter excursion changes no flag and no reset.
- R9: The stop-mode output is high only while a stop request is present with detect enable (bit 0) and detect-in-stop enable (bit 3) both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| cmp_below_rearm | input | 1 | Supply below power-on re-arm level (async) |
| cmp_below_det_hi | input | 1 | Supply below high detect threshold (async) |
| cmp_below_det_lo | input | 1 | Supply below low detect threshold (async) |
| cmp_below_warn_hi | input | 1 | Supply below high warning threshold (async) |
| cmp_below_warn_lo | input | 1 | Supply below low warning threshold (async) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| stop_req | input | 1 | Stop request from the core |
| sys_rst_out | output | 1 | System reset, active high |
| det_irq | output | 1 | Detect interrupt request |
| warn_irq | output | 1 | Warning interrupt request |
| stop_keep_detect | output | 1 | Stop should enter the mode that keeps detection alive |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands while the flag's set condition still holds. Only then does the set-over-clear priority show. The bench holds the supply level below the warning threshold for well beyond the filter window and writes the acknowledge during that time. It then checks that the flag survives. Next it removes the excursion and checks that a second acknowledge clears the flag. The low-voltage source bit is set only at release, so the bench reads it twice: once while reset is still held, and once after the supply has recovered.

// File: rtl/svs_pkg.sv
package svs_pkg;
    localparam int unsigned REG_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_SRC  = 2'd2;
    localparam logic [1:0] ADDR_FILT = 2'd3;

    // comparator lane order inside the synchronizer
    localparam int unsigned LANE_REARM   = 0;
    localparam int unsigned LANE_DET_HI  = 1;
    localparam int unsigned LANE_DET_LO  = 2;
    localparam int unsigned LANE_WARN_HI = 3;
    localparam int unsigned LANE_WARN_LO = 4;
    localparam int unsigned NUM_LANES    = 5;

    typedef struct packed {
        logic warn_ie;
        logic warn_sel;
        logic det_sel;
        logic det_stop_en;
        logic det_ie;
        logic det_rst_en;
        logic det_en;
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = '{warn_ie: 1'b0, warn_sel: 1'b0, det_sel: 1'b0,
                                      det_stop_en: 1'b0, det_ie: 1'b0,
                                      det_rst_en: 1'b1, det_en: 1'b1};

    function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.det_en      = w[0];
        c.det_rst_en  = w[1];
        c.det_ie      = w[2];
        c.det_stop_en = w[3];
        c.det_sel     = w[4];
        c.warn_sel    = w[5];
        c.warn_ie     = w[6];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w    = '0;
        w[0] = c.det_en;
        w[1] = c.det_rst_en;
        w[2] = c.det_ie;
        w[3] = c.det_stop_en;
        w[4] = c.det_sel;
        w[5] = c.warn_sel;
        w[6] = c.warn_ie;
        return w;
    endfunction
endpackage

// File: rtl/svs_sync.sv
module svs_sync #(
    parameter int unsigned     W       = 5,
    parameter int unsigned     STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/svs_persist.sv
module svs_persist #(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          level,
    input  logic [CW-1:0] limit,
    output logic          qualified
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!level) begin
            cnt_d = '0;
        end else if (cnt_q < limit) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign qualified = level && (cnt_q >= limit);
endmodule

// File: rtl/svs_ctrl.sv
module svs_ctrl
    import svs_pkg::*;
#(
    parameter int unsigned FILT_W   = 6,
    parameter int unsigned FILT_DEF = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_below_rearm,
    input  logic             cmp_below_det_hi,
    input  logic             cmp_below_det_lo,
    input  logic             cmp_below_warn_hi,
    input  logic             cmp_below_warn_lo,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             stop_req,
    output logic             sys_rst_out,
    output logic             det_irq,
    output logic             warn_irq,
    output logic             stop_keep_detect
);
    localparam int unsigned    PAD_W     = REG_W - FILT_W;
    localparam logic [FILT_W-1:0] LIM_DEF = FILT_W'(FILT_DEF);
    localparam int unsigned    NUM_FILT  = 2;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [FILT_W-1:0] lim;
        logic              det_flag;
        logic              warn_flag;
        logic              rst_hold;
        logic              hold_por;
        logic              src_por;
        logic              src_lv;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_LANES-1:0] lanes_raw, lanes_s;
    logic por_s, det_hi_s, det_lo_s, warn_hi_s, warn_lo_s;
    logic det_lvl, warn_lvl;
    logic [NUM_FILT-1:0] filt_lvl, filt_qual;
    logic det_qual, warn_qual;
    logic det_rst_evt, det_flag_set, warn_flag_set, release_ok;

    assign lanes_raw[LANE_REARM]   = cmp_below_rearm;
    assign lanes_raw[LANE_DET_HI]  = cmp_below_det_hi;
    assign lanes_raw[LANE_DET_LO]  = cmp_below_det_lo;
    assign lanes_raw[LANE_WARN_HI] = cmp_below_warn_hi;
    assign lanes_raw[LANE_WARN_LO] = cmp_below_warn_lo;

    svs_sync #(.W(NUM_LANES), .STAGES(2), .RST_VAL({NUM_LANES{1'b1}})) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lanes_raw),
        .sync_out (lanes_s)
    );

    assign por_s     = lanes_s[LANE_REARM];
    assign det_hi_s  = lanes_s[LANE_DET_HI];
    assign det_lo_s  = lanes_s[LANE_DET_LO];
    assign warn_hi_s = lanes_s[LANE_WARN_HI];
    assign warn_lo_s = lanes_s[LANE_WARN_LO];

    assign det_lvl  = st_q.ctrl.det_sel  ? det_hi_s  : det_lo_s;
    assign warn_lvl = st_q.ctrl.warn_sel ? warn_hi_s : warn_lo_s;

    assign filt_lvl[0] = det_lvl;
    assign filt_lvl[1] = warn_lvl;

    generate
        for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
            svs_persist #(.CW(FILT_W)) u_persist (
                .clk       (clk),
                .rst_n     (rst_n),
                .level     (filt_lvl[g]),
                .limit     (st_q.lim),
                .qualified (filt_qual[g])
            );
        end
    endgenerate

    assign det_qual  = filt_qual[0];
    assign warn_qual = filt_qual[1];

    always_comb begin
        st_d = st_q;

        det_rst_evt   = st_q.ctrl.det_en && st_q.ctrl.det_rst_en && det_qual;
        det_flag_set  = st_q.ctrl.det_en && !st_q.ctrl.det_rst_en && det_qual;
        warn_flag_set = st_q.ctrl.det_en && warn_qual && !det_lvl;
        release_ok    = st_q.hold_por ? !det_lo_s : !det_lvl;

        // register writes
        if (reg_we) begin
            unique case (reg_addr)
                ADDR_CTRL: st_d.ctrl = ctrl_from_word(reg_wdata);
                ADDR_STAT: begin
                    if (reg_wdata[1]) st_d.det_flag  = 1'b0;
                    if (reg_wdata[3]) st_d.warn_flag = 1'b0;
                end
                ADDR_SRC: begin
                    if (reg_wdata[0]) st_d.src_por = 1'b0;
                    if (reg_wdata[1]) st_d.src_lv  = 1'b0;
                end
                ADDR_FILT: st_d.lim = reg_wdata[FILT_W-1:0];
                default: ;
            endcase
        end

        // set events win over same-cycle clears
        if (det_flag_set)  st_d.det_flag  = 1'b1;
        if (warn_flag_set) st_d.warn_flag = 1'b1;

        // reset sequencing
        if (por_s) begin
            st_d.ctrl      = CTRL_DEFAULT;
            st_d.lim       = LIM_DEF;
            st_d.det_flag  = 1'b0;
            st_d.warn_flag = 1'b0;
            st_d.rst_hold  = 1'b1;
            st_d.hold_por  = 1'b1;
            st_d.src_por   = 1'b1;
            st_d.src_lv    = 1'b1;
        end else if (st_q.rst_hold) begin
            if (release_ok) begin
                st_d.rst_hold = 1'b0;
                st_d.hold_por = 1'b0;
                if (!st_q.hold_por) st_d.src_lv = 1'b1;
            end
        end else if (det_rst_evt) begin
            st_d.rst_hold = 1'b1;
            st_d.hold_por = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl      <= CTRL_DEFAULT;
            st_q.lim       <= LIM_DEF;
            st_q.det_flag  <= 1'b0;
            st_q.warn_flag <= 1'b0;
            st_q.rst_hold  <= 1'b1;
            st_q.hold_por  <= 1'b1;
            st_q.src_por   <= 1'b1;
            st_q.src_lv    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_to_word(st_q.ctrl);
            ADDR_STAT: begin
                reg_rdata[0] = st_q.det_flag;
                reg_rdata[2] = st_q.warn_flag;
            end
            ADDR_SRC: begin
                reg_rdata[0] = st_q.src_por;
                reg_rdata[1] = st_q.src_lv;
            end
            ADDR_FILT: reg_rdata = {{PAD_W{1'b0}}, st_q.lim};
            default: ;
        endcase
    end

    assign sys_rst_out      = st_q.rst_hold;
    assign det_irq          = st_q.det_flag && st_q.ctrl.det_ie;
    assign warn_irq         = st_q.warn_flag && st_q.ctrl.warn_ie;
    assign stop_keep_detect = stop_req && st_q.ctrl.det_en && st_q.ctrl.det_stop_en;
endmodule

// File: rtl/svs_ctrl_chk.sv
module svs_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_s,
    input logic       det_lvl,
    input logic       det_lo_s,
    input logic       hold_q,
    input logic       hold_por_q,
    input logic       det_flag_q,
    input logic       warn_flag_q,
    input logic       det_flag_set,
    input logic       det_rst_en,
    input logic       src_lv_q,
    input logic       sys_rst_out,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_rdata
);
    // R1
    por_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_s |=> sys_rst_out);

    // R4
    hold_until_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !hold_por_q && det_lvl) |=> sys_rst_out);

    // R1
    por_hold_until_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && hold_por_q && det_lo_s) |=> sys_rst_out);

    // R6
    set_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det_flag_set && !por_s) |=> det_flag_q);

    // R6
    ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd1) |-> (reg_rdata[1] == 1'b0 && reg_rdata[3] == 1'b0));

    // R5
    flag_only_in_irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_flag_q) |-> $past(!det_rst_en));

    // R7
    warn_above_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_flag_q) |-> $past(!det_lvl));

    // R2
    lv_source_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_lv_q) |-> $past(hold_q || por_s));
endmodule

bind svs_ctrl svs_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_s        (por_s),
    .det_lvl      (det_lvl),
    .det_lo_s     (det_lo_s),
    .hold_q       (st_q.rst_hold),
    .hold_por_q   (st_q.hold_por),
    .det_flag_q   (st_q.det_flag),
    .warn_flag_q  (st_q.warn_flag),
    .det_flag_set (det_flag_set),
    .det_rst_en   (st_q.ctrl.det_rst_en),
    .src_lv_q     (st_q.src_lv),
    .sys_rst_out  (sys_rst_out),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata)
);

// File: tb/svs_ctrl_test.sv
`timescale 1ns/1ps
module svs_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       c_rearm = 1'b1, c_dhi = 1'b1, c_dlo = 1'b1, c_whi = 1'b1, c_wlo = 1'b1;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       stop_req = 1'b0;
    logic       rst_out, dirq, wirq, keep;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    svs_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cmp_below_rearm(c_rearm), .cmp_below_det_hi(c_dhi), .cmp_below_det_lo(c_dlo),
        .cmp_below_warn_hi(c_whi), .cmp_below_warn_lo(c_wlo),
        .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .stop_req(stop_req), .sys_rst_out(rst_out), .det_irq(dirq), .warn_irq(wirq),
        .stop_keep_detect(keep)
    );

    // supply: 5 healthy, 4 below warn_hi, 3 below warn_lo, 2 below det_hi, 1 below det_lo, 0 below re-arm
    task automatic set_supply(input int v);
        @(negedge clk);
        c_rearm = (v < 1);
        c_dlo   = (v < 2);
        c_dhi   = (v < 3);
        c_wlo   = (v < 4);
        c_whi   = (v < 5);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {supply[2:0], ctrl[7:0], rst, det_irq, warn_irq, status[7:0]}
    localparam int NV = 12;
    localparam logic [21:0] VEC [NV] = '{
        {3'd4, 8'h45, 3'b000, 8'h00},  // R7 low warn sel, only above-high dip
        {3'd4, 8'h65, 3'b001, 8'h04},  // R7 high warn sel
        {3'd3, 8'h45, 3'b001, 8'h04},  // R7
        {3'd2, 8'h45, 3'b001, 8'h04},  // R7 above low detect
        {3'd2, 8'h55, 3'b010, 8'h01},  // R3 high detect sel, R5
        {3'd1, 8'h45, 3'b010, 8'h01},  // R5
        {3'd1, 8'h44, 3'b000, 8'h00},  // R3 disabled
        {3'd1, 8'h41, 3'b000, 8'h01},  // R5 flag without ie
        {3'd1, 8'h47, 3'b100, 8'h00},  // R4 reset mode
        {3'd2, 8'h57, 3'b100, 8'h00},  // R4 high threshold reset
        {3'd2, 8'h47, 3'b001, 8'h04},  // R4 no reset above low
        {3'd4, 8'h25, 3'b000, 8'h04}   // R7 flag without warn ie
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        // power-up with supply absent
        set_supply(0);
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(20);
        chk("R1 reset at power-on", {7'd0, rst_out}, 8'h01);
        rd(2'd2, r); chk("R2 both source bits after POR", r, 8'h03);
        rd(2'd0, r); chk("R1 ctrl default", r, 8'h03);
        rd(2'd3, r); chk("R1 filter default", r, 8'h04);
        set_supply(1);
        wait_cyc(20);
        chk("R1 held below low detect", {7'd0, rst_out}, 8'h01);
        set_supply(2);
        wait_cyc(10);
        chk("R1 released above low detect", {7'd0, rst_out}, 8'h00);
        wr(2'd2, 8'h01);
        rd(2'd2, r); chk("R2 w1c power-on bit", r, 8'h02);
        set_supply(5);
        wr(2'd3, 8'h03);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] sup;
            logic [7:0] ctl, st;
            logic [2:0] outs;
            {sup, ctl, outs, st} = VEC[i];
            set_supply(5);
            wait_cyc(40);
            wr(2'd1, 8'h0A);
            wr(2'd0, ctl);
            set_supply(int'(sup));
            wait_cyc(40);
            chk($sformatf("R3/R4/R5/R7 vector %0d outputs", i), {5'd0, rst_out, dirq, wirq}, {5'd0, outs});
            rd(2'd1, r);
            chk($sformatf("R5/R7 vector %0d status", i), r, st);
        end
        set_supply(5);
        wait_cyc(40);

        // R4 low-voltage source bit set only at release
        wr(2'd2, 8'h03);
        rd(2'd2, r); chk("R2 sources cleared", r, 8'h00);
        wr(2'd0, 8'h03);
        set_supply(1);
        wait_cyc(30);
        chk("R4 reset asserted", {7'd0, rst_out}, 8'h01);
        rd(2'd2, r); chk("R4 lv bit clear while held", r, 8'h00);
        set_supply(5);
        wait_cyc(10);
        chk("R4 reset released", {7'd0, rst_out}, 8'h00);
        rd(2'd2, r); chk("R4 lv bit set after release", r, 8'h02);

        // R6 ack during persisting condition
        wr(2'd1, 8'h0A);
        wr(2'd0, 8'h65);
        set_supply(4);
        wait_cyc(30);
        wr(2'd1, 8'h08);
        rd(2'd1, r); chk("R6 flag kept while set condition holds", r, 8'h04);
        set_supply(5);
        wait_cyc(30);
        rd(2'd1, r); chk("R6 flag sticky after recovery", r, 8'h04);
        wr(2'd1, 8'h08);
        rd(2'd1, r); chk("R6 ack clears warn flag", r, 8'h00);
        wr(2'd0, 8'h45);
        set_supply(1);
        wait_cyc(30);
        set_supply(5);
        wait_cyc(30);
        wr(2'd1, 8'h02);
        rd(2'd1, r); chk("R6 ack clears detect flag, ack bits read 0", r, 8'h00);

        // R8 filter
        wr(2'd3, 8'h0A);
        set_supply(3);
        wait_cyc(4);
        set_supply(5);
        wait_cyc(30);
        rd(2'd1, r); chk("R8 short dip ignored", r, 8'h00);
        set_supply(3);
        wait_cyc(40);
        rd(2'd1, r); chk("R8 long dip counted", r, 8'h04);
        set_supply(5);
        wait_cyc(30);
        wr(2'd1, 8'h0A);

        // R9 stop mode select
        stop_req = 1'b1;
        wr(2'd0, 8'h0B);
        #1 chk("R9 keep detect in stop", {7'd0, keep}, 8'h01);
        wr(2'd0, 8'h03);
        #1 chk("R9 no stop-enable", {7'd0, keep}, 8'h00);
        wr(2'd0, 8'h0A);
        #1 chk("R9 detection disabled", {7'd0, keep}, 8'h00);
        stop_req = 1'b0;
        wr(2'd0, 8'h0B);
        #1 chk("R9 no stop request", {7'd0, keep}, 8'h00);

        // R1 brown-out to re-arm while running
        wr(2'd0, 8'h65);
        set_supply(0);
        wait_cyc(10);
        chk("R1 re-arm reset", {7'd0, rst_out}, 8'h01);
        rd(2'd0, r); chk("R1 ctrl back to default", r, 8'h03);
        rd(2'd2, r); chk("R2 both bits after re-arm", r, 8'h03);
        set_supply(5);
        wait_cyc(10);
        chk("R1 release after re-arm", {7'd0, rst_out}, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule